// File: doc/BRIEF.md
# Double-precision to signed integer truncating converter

This unit turns a 64-bit IEEE-754 binary64 value into a signed two's-complement integer. It always truncates toward zero. A run-time width select picks a 32-bit or a 64-bit result. Beside the integer it reports two floating-point exception indications: an invalid-operation flag and an inexact flag. It drives no other condition flags. There is no rounding-mode input, so the result never depends on a dynamic rounding setting.

The unit is one pipeline stage. An operand presented with `inValid` high is captured at a rising clock edge, and the result, the flags and `outValid` appear in the following cycle. A source whose truncated value does not fit the selected width returns the masked-response "integer indefinite" pattern, in which only the sign bit of the selected width is set, and raises invalid. NaN and infinity inputs give the same response. Trapping, instruction decode, operand fetch and register writeback belong to the surrounding pipeline.

Top module: `fp2int_trunc`

## Requirements
- R1: An operand accepted with `inValid` high at a rising edge produces `outValid` high in the next cycle. In a cycle that follows an edge with `inValid` low, `outValid` is low and `outInt`, `flagInvalid` and `flagInexact` keep their previous values.
- R2: An in-range source is truncated toward zero. A negative source yields the two's complement of its truncated magnitude (for example, -1.5 gives -1 and 2.75 gives 2).
- R3: With `wideSel` = 1, `outInt[63:0]` carries the signed 64-bit result.
- R4: With `wideSel` = 0, `outInt[31:0]` carries the signed 32-bit result and `outInt[63:32]` is zero.
- R5: When the truncated value lies outside the signed range of the selected width, `flagInvalid` = 1, `flagInexact` = 0 and `outInt` is 0x8000_0000_0000_0000 (wide) or 0x0000_0000_8000_0000 (narrow).
- R6: A source with exponent field all ones (NaN of either kind, or ±infinity) gives the same response as R5 for the selected width.
- R7: A source that truncates to exactly -2^31 (narrow) or -2^63 (wide) is representable. It returns that value with `flagInvalid` = 0, and `flagInexact` is set only if nonzero fraction bits were dropped (for example, -2147483648.5 in narrow mode).
- R8: A source with magnitude below 1.0, including subnormals and -0.0, returns 0. `flagInexact` is 1 for any nonzero such source, and ±0.0 raises neither flag.
- R9: For an in-range result, `flagInexact` is 1 exactly when the source has a nonzero fractional part, and `flagInvalid` is 0.
- R10: While `rstN` is low, `outValid`, `outInt`, `flagInvalid` and `flagInexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand present this cycle |
| fpBits | input | 64 | binary64 source operand (sign bit 63, exponent bits 62:52, fraction bits 51:0) |
| wideSel | input | 1 | 1 selects a 64-bit result, 0 selects a 32-bit result |
| outValid | output | 1 | Result valid, one cycle after the operand |
| outInt | output | 64 | Signed integer result; upper half zero in narrow mode |
| flagInvalid | output | 1 | Invalid-operation indication |
| flagInexact | output | 1 | Precision (inexact) indication |

## Verification
The bench builds the block with its default format parameters: an 11-bit exponent, a 52-bit fraction, and 64-bit and 32-bit result widths. With these values the alignment shifter spans its full 0 to 63 position range. The exponents that sit exactly on each width's sign-bit boundary, which the random exponent bias concentrates on, are then reachable. Directed operands sit on both sides of -2^31 and -2^63, include the largest positive values of each width, and cover NaN, infinities, subnormals and signed zeros. In both modes, results are compared against a model that decides range from real-number comparisons.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int EXP_W    = 11;
  localparam int MAN_W    = 52;
  localparam int FP_W     = 1 + EXP_W + MAN_W;
  localparam int WIDE_W   = 64;
  localparam int NARROW_W = 32;
  localparam int SHAMT_W  = $clog2(WIDE_W);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;

  // Strobes from the classifier to the datapath
  typedef struct packed {
    logic forceIndef;   // result is the indefinite pattern
    logic forceZero;    // magnitude below one
    logic edgeCheck;    // exponent on the sign-bit boundary with negative sign
    logic negate;       // source is negative
    logic tinyInexact;  // nonzero value below one
    logic wide;         // 64-bit result selected
  } cvtStrobe_t;
endpackage

// File: rtl/fp2int_align.sv
module fp2int_align
  import fp2int_pkg::*;
(
  input  logic [MAN_W-1:0]   frac,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [WIDE_W-1:0]  mag,
  output logic               lost
);
  // Fixed point: WIDE_W integer bits above MAN_W fraction bits
  localparam int EXT_W = WIDE_W + MAN_W;

  logic [EXT_W-1:0] stage [SHAMT_W+1];

  assign stage[0] = EXT_W'({1'b1, frac});

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign mag  = stage[SHAMT_W][EXT_W-1:MAN_W];
  assign lost = |stage[SHAMT_W][MAN_W-1:0];
endmodule

// File: rtl/fp2int_ctl.sv
module fp2int_ctl
  import fp2int_pkg::*;
(
  input  logic [FP_W-1:0]    fpBits,
  input  logic               wideSel,
  output cvtStrobe_t         strobe,
  output logic [SHAMT_W-1:0] shamt
);
  localparam logic [EXP_W-1:0] BIAS_E      = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EDGE_WIDE   = EXP_W'(BIAS + WIDE_W - 1);
  localparam logic [EXP_W-1:0] EDGE_NARROW = EXP_W'(BIAS + NARROW_W - 1);

  logic             sgn;
  logic [EXP_W-1:0] rawExp;
  logic             fracNz;
  logic [EXP_W-1:0] edgeExp;
  logic             isSpecial;
  logic             isTiny;
  logic             overRange;
  logic             atEdge;

  always_comb begin
    sgn       = fpBits[FP_W-1];
    rawExp    = fpBits[FP_W-2:MAN_W];
    fracNz    = |fpBits[MAN_W-1:0];
    edgeExp   = wideSel ? EDGE_WIDE : EDGE_NARROW;
    isSpecial = &rawExp;
    isTiny    = rawExp < BIAS_E;
    overRange = rawExp > edgeExp;
    atEdge    = rawExp == edgeExp;

    strobe.forceIndef  = isSpecial | overRange | (atEdge & ~sgn);
    strobe.forceZero   = isTiny;
    strobe.edgeCheck   = atEdge & sgn;
    strobe.negate      = sgn;
    strobe.tinyInexact = isTiny & ((|rawExp) | fracNz);
    strobe.wide        = wideSel;

    shamt = SHAMT_W'(rawExp - BIAS_E);
  end
endmodule

// File: rtl/fp2int_dp.sv
module fp2int_dp
  import fp2int_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [MAN_W-1:0]   frac,
  input  logic [SHAMT_W-1:0] shamt,
  input  cvtStrobe_t         strobe,
  output logic               outValid,
  output logic [WIDE_W-1:0]  outInt,
  output logic               flagInvalid,
  output logic               flagInexact
);
  localparam logic [WIDE_W-1:0] MIN_WIDE   = WIDE_W'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] MIN_NARROW = WIDE_W'(1) << (NARROW_W - 1);

  logic [WIDE_W-1:0] mag;
  logic              lost;
  logic [WIDE_W-1:0] edgeMin;
  logic [WIDE_W-1:0] signedVal;
  logic              invNext;
  logic              inxNext;
  logic [WIDE_W-1:0] resNext;

  fp2int_align u_align (
    .frac  (frac),
    .shamt (shamt),
    .mag   (mag),
    .lost  (lost)
  );

  always_comb begin
    edgeMin   = strobe.wide ? MIN_WIDE : MIN_NARROW;
    invNext   = strobe.forceIndef | (strobe.edgeCheck & (mag != edgeMin));
    signedVal = strobe.negate ? (~mag + WIDE_W'(1)) : mag;
    if (invNext) begin
      resNext = edgeMin;
      inxNext = 1'b0;
    end else if (strobe.forceZero) begin
      resNext = '0;
      inxNext = strobe.tinyInexact;
    end else begin
      resNext = strobe.wide ? signedVal
                            : {{(WIDE_W-NARROW_W){1'b0}}, signedVal[NARROW_W-1:0]};
      inxNext = lost;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outInt      <= '0;
      flagInvalid <= 1'b0;
      flagInexact <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outInt      <= resNext;
        flagInvalid <= invNext;
        flagInexact <= inxNext;
      end
    end
  end
endmodule

// File: rtl/fp2int_trunc.sv
module fp2int_trunc
  import fp2int_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FP_W-1:0]   fpBits,
  input  logic              wideSel,
  output logic              outValid,
  output logic [WIDE_W-1:0] outInt,
  output logic              flagInvalid,
  output logic              flagInexact
);
  cvtStrobe_t         strobe;
  logic [SHAMT_W-1:0] shamt;

  fp2int_ctl u_ctl (
    .fpBits  (fpBits),
    .wideSel (wideSel),
    .strobe  (strobe),
    .shamt   (shamt)
  );

  fp2int_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .frac        (fpBits[MAN_W-1:0]),
    .shamt       (shamt),
    .strobe      (strobe),
    .outValid    (outValid),
    .outInt      (outInt),
    .flagInvalid (flagInvalid),
    .flagInexact (flagInexact)
  );
endmodule

// File: rtl/fp2int_trunc_chk.sv
module fp2int_trunc_chk
  import fp2int_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [FP_W-1:0]   fpBits,
  input logic              wideSel,
  input logic              outValid,
  input logic [WIDE_W-1:0] outInt,
  input logic              flagInvalid,
  input logic              flagInexact
);
  localparam logic [WIDE_W-1:0] IND_WIDE   = WIDE_W'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] IND_NARROW = WIDE_W'(1) << (NARROW_W - 1);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outInt) && $stable(flagInvalid) && $stable(flagInexact))); // R1

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !wideSel) |=> (outInt[WIDE_W-1:NARROW_W] == '0)); // R4

  AST_INDEF_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && wideSel) |=> (!flagInvalid || (outInt == IND_WIDE))); // R5

  AST_INDEF_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !wideSel) |=> (!flagInvalid || (outInt == IND_NARROW))); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(flagInvalid && flagInexact)); // R5

  AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&fpBits[FP_W-2:MAN_W])) |=> (flagInvalid && !flagInexact)); // R6

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (fpBits[FP_W-2:0] == '0)) |=> (outInt == '0 && !flagInvalid && !flagInexact)); // R8
endmodule

bind fp2int_trunc fp2int_trunc_chk u_chk (.*);

// File: tb/fp2int_trunc_tb.sv
`timescale 1ns/1ps
module fp2int_trunc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] fpBits = '0;
  logic        wideSel = 1'b0;
  logic        outValid;
  logic [63:0] outInt;
  logic        flagInvalid;
  logic        flagInexact;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp2int_trunc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fpBits(fpBits), .wideSel(wideSel),
    .outValid(outValid), .outInt(outInt), .flagInvalid(flagInvalid), .flagInexact(flagInexact)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent model: range from real comparisons, magnitude from the bit fields
  task automatic model(input logic [63:0] b, input logic w, output logic [63:0] r,
                       output logic inv, output logic inx, output string tag);
    real x;
    logic [10:0] ex;
    logic [63:0] sig, m, t;
    longint tl;
    int sh;
    x  = $bitstoreal(b);
    ex = b[62:52];
    if (ex == 11'h7ff) begin
      inv = 1'b1; tag = "R6";
    end else if (w) begin
      inv = (x >= 9223372036854775808.0) || (x < -9223372036854775808.0); tag = "R5";
    end else begin
      inv = (x >= 2147483648.0) || (x <= -2147483649.0); tag = "R5";
    end
    if (inv) begin
      r   = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      inx = 1'b0;
      return;
    end
    if (ex < 11'd1023) begin
      m = '0; tag = "R8";
    end else begin
      sig = {11'b0, 1'b1, b[51:0]};
      sh  = int'(ex) - 1023;
      m   = (sh >= 52) ? (sig << (sh - 52)) : (sig >> (52 - sh));
      tag = w ? "R3" : "R4";
      if (b[63]) tag = "R2";
      if (b[63] && ((w && m == 64'h8000_0000_0000_0000) || (!w && m == 64'h8000_0000)))
        tag = "R7";
    end
    t   = b[63] ? (~m + 64'd1) : m;
    tl  = longint'(t);
    inx = (real'(tl) != x);
    r   = w ? t : {32'b0, t[31:0]};
  endtask

  // Starts at a falling edge; checks at the next falling edge
  task automatic run(input logic [63:0] b, input logic w);
    logic [63:0] er;
    logic ei, ex;
    string tag;
    model(b, w, er, ei, ex, tag);
    fpBits = b; wideSel = w; inValid = 1'b1;
    @(negedge clk);
    chk("R1", "outValid", 64'(outValid), 64'd1);
    chk(tag, "outInt", outInt, er);
    chk(tag, "flagInvalid", 64'(flagInvalid), 64'(ei));
    chk((tag == "R3" || tag == "R4" || tag == "R2") ? "R9" : tag, "flagInexact",
        64'(flagInexact), 64'(ex));
    if (!w) chk("R4", "upper half", 64'(outInt[63:32]), 64'd0);
    inValid = 1'b0;
  endtask

  task automatic idleCheck();
    logic [63:0] keepInt;
    logic keepInv, keepInx;
    keepInt = outInt; keepInv = flagInvalid; keepInx = flagInexact;
    fpBits  = 64'h7ff8_0000_0000_0000; wideSel = ~wideSel; inValid = 1'b0;
    @(negedge clk);
    chk("R1", "idle outValid", 64'(outValid), 64'd0);
    chk("R1", "idle outInt", outInt, keepInt);
    chk("R1", "idle flags", {62'b0, flagInvalid, flagInexact}, {62'b0, keepInv, keepInx});
  endtask

  initial begin
    logic [10:0] ex;
    logic [51:0] fr;
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    chk("R10", "reset outValid", 64'(outValid), 64'd0);
    chk("R10", "reset outInt", outInt, 64'd0);
    chk("R10", "reset flags", {62'b0, flagInvalid, flagInexact}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners, each in both widths
    for (int w = 0; w < 2; w++) begin
      run($realtobits(0.0), w[0]);
      run(64'h8000_0000_0000_0000, w[0]);             // -0.0
      run($realtobits(1.5), w[0]);
      run($realtobits(-1.5), w[0]);
      run($realtobits(2.75), w[0]);
      run($realtobits(0.5), w[0]);
      run($realtobits(-0.999), w[0]);
      run(64'h0000_0000_0000_0001, w[0]);             // subnormal
      run($realtobits(2147483647.5), w[0]);
      run($realtobits(2147483648.0), w[0]);
      run($realtobits(-2147483648.0), w[0]);
      run($realtobits(-2147483648.5), w[0]);
      run($realtobits(-2147483649.0), w[0]);
      run($realtobits(9223372036854775808.0), w[0]);
      run($realtobits(-9223372036854775808.0), w[0]);
      run(64'h43df_ffff_ffff_ffff, w[0]);             // largest below 2^63
      run(64'hc3e0_0000_0000_0001, w[0]);             // just below -2^63
      run(64'h7ff0_0000_0000_0000, w[0]);             // +inf
      run(64'hfff0_0000_0000_0000, w[0]);             // -inf
      run(64'h7ff8_0000_0000_0000, w[0]);             // quiet NaN
      run(64'h7ff0_0000_0000_0001, w[0]);             // signalling NaN
      idleCheck();
    end

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 8)
        0: ex = 11'($urandom);
        1: ex = 11'h7ff;
        2: ex = 11'(1000 + $urandom % 23);
        default: ex = 11'(1021 + $urandom % 68);
      endcase
      fr = {20'($urandom), 32'($urandom)};
      if ($urandom % 3 == 0) fr[31:0] = '0;
      run({1'($urandom), ex, fr}, 1'($urandom));
      if ($urandom % 16 == 0) idleCheck();
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule